// File: doc/BRIEF.md
# Quick-Channel Trigger and Completion Controller

This block holds the register and event logic for a bank of eight quick DMA channels. Software links each channel to a parameter slot and to one word inside that slot. It then enables the channel's events. The block watches a snooped write port into the parameter-slot window. When software writes the linked word of an enabled channel, the channel latches an event, and the block later emits a single request pulse. That pulse carries the channel number and the slot number. A transfer engine, outside this block, performs the move and reports back with a 6-bit completion code. Each code sets one bit of a 64-bit interrupt-pending state, which software clears with write-1-to-clear registers.

Latched events are issued by a two-state arbiter. In `ARB_IDLE` it picks the lowest-numbered channel that has a latched event, captures that channel's slot number, and moves to `ARB_ISSUE`. In `ARB_ISSUE` it drives `req_valid` for exactly one cycle, drops the event, and always returns to `ARB_IDLE`. A channel stays busy from its trigger until software clears its busy flag. A trigger that arrives while the channel is busy is recorded as a missed event and issues no request.

Register map, as byte offsets on the register bus:
- 0x200 + 4*ch: channel link register.
- 0x300: enable set.
- 0x304: enable clear.
- 0x308: missed flags.
- 0x30C: missed clear.
- 0x310: busy flags.
- 0x314: busy clear.
- 0x320 / 0x324: pending, low and high word.
- 0x328 / 0x32C: pending clear, low and high word.

Reads are combinational from `reg_addr`.

Top module: `qtc_ctrl`

## Requirements
- R1: After reset, the enable, busy, missed and pending registers all read zero, every link register reads zero, and `req_valid` is low.
- R2: The link register of channel ch is at 0x200 + 4*ch. It holds a 9-bit slot number in bits 13:5 and a 3-bit word index in bits 4:2. It reads back those bits, and all other bits read zero. A link value of zero (slot 0, word 0) means the channel is unlinked and cannot trigger.
- R3: A 1 written to bit ch of 0x300 enables channel ch, and a 1 written to bit ch of 0x304 disables it. Zero bits leave the state unchanged. 0x300 reads the enable mask, and 0x304 reads zero.
- R4: A snooped write to byte address 0x4000 + 32*slot + 4*word, where (slot, word) matches an enabled, linked, non-busy channel, sets that channel's busy bit (read at 0x310). It also yields one `req_valid` pulse that carries `req_ch` and `req_slot`. The pulse is high during the second cycle after the write edge, and during no other cycle.
- R5: A matching snooped write to an enabled channel that is already busy sets that channel's missed bit (read at 0x308) and produces no request.
- R6: A snooped write that matches a disabled channel, or that targets an unlinked channel, produces no request and changes no busy or missed flag.
- R7: A 1 in bit ch written to 0x314 clears channel ch's busy flag, and a 1 written to 0x30C clears its missed flag. Both clear registers read zero.
- R8: When one snooped write triggers several channels, their requests come out one at a time in ascending channel order, two cycles apart.
- R9: A completion code k (0 to 63) with `cmp_valid` sets pending bit k. Codes 0 to 31 appear in 0x320 bit k, and codes 32 to 63 appear in 0x324 bit k-32.
- R10: Writing 1s to 0x328 or 0x32C clears the matching low or high pending bits. Zero bits have no effect, and both registers read zero. If a code sets a bit in the same cycle that a clear targets it, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address, for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| snp_we | input | 1 | Snooped parameter-slot write strobe |
| snp_addr | input | 16 | Snooped write byte address |
| cmp_valid | input | 1 | Completion code valid |
| cmp_code | input | 6 | Completion code |
| req_valid | output | 1 | One-cycle transfer request |
| req_ch | output | 3 | Channel of the request |
| req_slot | output | 9 | Linked slot number of the request |

## Verification
The bench uses the default parameters: eight channels, a 9-bit slot number, a 3-bit word index, a 16-bit address and 64 completion codes. With these values the snooped address uses every bit of its slot and word fields, including slot 511 with word 7. The pending state spans both 32-bit words, so both codes 31/32 and codes 0/63 are checked. Eight channels also allow two channels to be linked to the same word, which makes the arbiter's ascending order visible.

// File: rtl/qtc_pkg.sv
package qtc_pkg;

    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_ISSUE = 1'b1
    } arb_state_t;

    localparam logic [15:0] OFS_LINK     = 16'h0200;
    localparam logic [15:0] OFS_EN_SET   = 16'h0300;
    localparam logic [15:0] OFS_EN_CLR   = 16'h0304;
    localparam logic [15:0] OFS_MISS     = 16'h0308;
    localparam logic [15:0] OFS_MISS_CLR = 16'h030C;
    localparam logic [15:0] OFS_BUSY     = 16'h0310;
    localparam logic [15:0] OFS_BUSY_CLR = 16'h0314;
    localparam logic [15:0] OFS_PEND_LO  = 16'h0320;
    localparam logic [15:0] OFS_PEND_HI  = 16'h0324;
    localparam logic [15:0] OFS_PCLR_LO  = 16'h0328;
    localparam logic [15:0] OFS_PCLR_HI  = 16'h032C;

endpackage

// File: rtl/qtc_chan_bank.sv
module qtc_chan_bank #(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned SLOT_W  = 9,
    parameter int unsigned WORD_W  = 3,
    parameter int unsigned AW      = 16,
    parameter int unsigned WIN_TAG = 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CH-1:0]              link_we,
    input  logic [31:0]                    wdata,
    input  logic [NUM_CH-1:0]              en_set,
    input  logic [NUM_CH-1:0]              en_clr,
    input  logic [NUM_CH-1:0]              busy_clr,
    input  logic [NUM_CH-1:0]              miss_clr,
    input  logic                           snp_we,
    input  logic [AW-1:0]                  snp_addr,
    output logic [NUM_CH-1:0][SLOT_W-1:0]  link_slot,
    output logic [NUM_CH-1:0][WORD_W-1:0]  link_word,
    output logic [NUM_CH-1:0]              en_q,
    output logic [NUM_CH-1:0]              busy_q,
    output logic [NUM_CH-1:0]              miss_q,
    output logic [NUM_CH-1:0]              fire
);

    localparam int unsigned WORD_LSB = 2;
    localparam int unsigned SLOT_LSB = WORD_LSB + WORD_W;
    localparam int unsigned TAG_LSB  = SLOT_LSB + SLOT_W;
    localparam int unsigned TAG_W    = AW - TAG_LSB;

    logic in_window;
    assign in_window = snp_we && (snp_addr[AW-1:TAG_LSB] == TAG_W'(WIN_TAG));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        logic linked;
        logic late;

        assign linked = (link_slot[g] != '0) || (link_word[g] != '0);
        assign hit    = in_window && linked
                        && (snp_addr[SLOT_LSB +: SLOT_W] == link_slot[g])
                        && (snp_addr[WORD_LSB +: WORD_W] == link_word[g])
                        && en_q[g];
        assign fire[g] = hit && !busy_q[g];
        assign late    = hit && busy_q[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                link_slot[g] <= '0;
                link_word[g] <= '0;
                en_q[g]      <= 1'b0;
                busy_q[g]    <= 1'b0;
                miss_q[g]    <= 1'b0;
            end else begin
                if (link_we[g]) begin
                    link_slot[g] <= wdata[SLOT_LSB +: SLOT_W];
                    link_word[g] <= wdata[WORD_LSB +: WORD_W];
                end
                en_q[g]   <= (en_q[g] | en_set[g]) & ~en_clr[g];
                busy_q[g] <= fire[g] | (busy_q[g] & ~busy_clr[g]);
                miss_q[g] <= late | (miss_q[g] & ~miss_clr[g]);
            end
        end

        // R5: a missed flag only appears on a channel that was already busy
        p_miss_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(miss_q[g]) |-> $past(busy_q[g]));

        // R6: a disabled channel never becomes busy
        p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy_q[g]) |-> $past(en_q[g]));
    end

endmodule

// File: rtl/qtc_arbiter.sv
module qtc_arbiter
    import qtc_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned SLOT_W = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0]             fire,
    input  logic [NUM_CH-1:0][SLOT_W-1:0] link_slot,
    output logic                          req_valid,
    output logic [$clog2(NUM_CH)-1:0]     req_ch,
    output logic [SLOT_W-1:0]             req_slot
);

    localparam int unsigned CH_W = $clog2(NUM_CH);

    arb_state_t        state_q, state_d;
    logic [NUM_CH-1:0] queue_q;
    logic [NUM_CH-1:0] drop;
    logic [CH_W-1:0]   pick;
    logic              found;
    logic [CH_W-1:0]   cur_ch;
    logic [SLOT_W-1:0] cur_slot;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (queue_q[i] && !found) begin
                pick  = CH_W'(i);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:  if (found) state_d = ARB_ISSUE;
            ARB_ISSUE: state_d = ARB_IDLE;
            default:   state_d = ARB_IDLE;
        endcase
    end

    always_comb begin
        drop = '0;
        if (state_q == ARB_ISSUE) drop[cur_ch] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ARB_IDLE;
            queue_q  <= '0;
            cur_ch   <= '0;
            cur_slot <= '0;
        end else begin
            state_q <= state_d;
            queue_q <= (queue_q & ~drop) | fire;
            if (state_q == ARB_IDLE && found) begin
                cur_ch   <= pick;
                cur_slot <= link_slot[pick];
            end
        end
    end

    always_comb begin
        req_valid = 1'b0;
        req_ch    = cur_ch;
        req_slot  = cur_slot;
        unique case (state_q)
            ARB_IDLE:  req_valid = 1'b0;
            ARB_ISSUE: req_valid = 1'b1;
            default:   req_valid = 1'b0;
        endcase
    end

    // R4: a request is a single-cycle pulse
    p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R8: a latched event seen while idle is issued on the next cycle
    p_issue_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_IDLE && queue_q != '0) |=> req_valid);

endmodule

// File: rtl/qtc_pend.sv
module qtc_pend #(
    parameter int unsigned CODES = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmp_valid,
    input  logic [$clog2(CODES)-1:0] cmp_code,
    input  logic                     clr_lo_we,
    input  logic                     clr_hi_we,
    input  logic [31:0]              wdata,
    output logic [CODES-1:0]         pend_q
);

    logic [CODES-1:0] set_mask;
    logic [CODES-1:0] clr_mask;

    always_comb begin
        set_mask = '0;
        if (cmp_valid) set_mask[cmp_code] = 1'b1;
        clr_mask = '0;
        if (clr_lo_we) clr_mask[31:0]  = wdata;
        if (clr_hi_we) clr_mask[63:32] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | set_mask;
    end

    // R9: a completion code always leaves its pending bit set
    p_code_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> pend_q[$past(cmp_code)]);

    // R10: a low clear of bit 0 with no competing set leaves bit 0 clear
    p_clear_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_lo_we && wdata[0] && !(cmp_valid && cmp_code == '0)) |=> !pend_q[0]);

endmodule

// File: rtl/qtc_ctrl.sv
module qtc_ctrl
    import qtc_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned SLOT_W = 9,
    parameter int unsigned WORD_W = 3,
    parameter int unsigned AW     = 16,
    parameter int unsigned CODES  = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_we,
    input  logic [AW-1:0]             reg_addr,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    input  logic                      snp_we,
    input  logic [AW-1:0]             snp_addr,
    input  logic                      cmp_valid,
    input  logic [$clog2(CODES)-1:0]  cmp_code,
    output logic                      req_valid,
    output logic [$clog2(NUM_CH)-1:0] req_ch,
    output logic [SLOT_W-1:0]         req_slot
);

    localparam int unsigned SLOT_LSB = 2 + WORD_W;

    logic [NUM_CH-1:0]              link_we;
    logic [NUM_CH-1:0]              en_set, en_clr, busy_clr, miss_clr;
    logic [NUM_CH-1:0][SLOT_W-1:0]  link_slot;
    logic [NUM_CH-1:0][WORD_W-1:0]  link_word;
    logic [NUM_CH-1:0]              en_q, busy_q, miss_q, fire;
    logic [CODES-1:0]               pend_q;
    logic                           clr_lo_we, clr_hi_we;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_link_dec
        assign link_we[g] = reg_we && (reg_addr == OFS_LINK + AW'(4 * g));
    end

    assign en_set    = (reg_we && reg_addr == OFS_EN_SET)   ? reg_wdata[NUM_CH-1:0] : '0;
    assign en_clr    = (reg_we && reg_addr == OFS_EN_CLR)   ? reg_wdata[NUM_CH-1:0] : '0;
    assign busy_clr  = (reg_we && reg_addr == OFS_BUSY_CLR) ? reg_wdata[NUM_CH-1:0] : '0;
    assign miss_clr  = (reg_we && reg_addr == OFS_MISS_CLR) ? reg_wdata[NUM_CH-1:0] : '0;
    assign clr_lo_we = reg_we && (reg_addr == OFS_PCLR_LO);
    assign clr_hi_we = reg_we && (reg_addr == OFS_PCLR_HI);

    qtc_chan_bank #(
        .NUM_CH (NUM_CH),
        .SLOT_W (SLOT_W),
        .WORD_W (WORD_W),
        .AW     (AW),
        .WIN_TAG(1)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_we  (link_we),
        .wdata    (reg_wdata),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .busy_clr (busy_clr),
        .miss_clr (miss_clr),
        .snp_we   (snp_we),
        .snp_addr (snp_addr),
        .link_slot(link_slot),
        .link_word(link_word),
        .en_q     (en_q),
        .busy_q   (busy_q),
        .miss_q   (miss_q),
        .fire     (fire)
    );

    qtc_arbiter #(
        .NUM_CH(NUM_CH),
        .SLOT_W(SLOT_W)
    ) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .link_slot(link_slot),
        .req_valid(req_valid),
        .req_ch   (req_ch),
        .req_slot (req_slot)
    );

    qtc_pend #(
        .CODES(CODES)
    ) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_valid(cmp_valid),
        .cmp_code (cmp_code),
        .clr_lo_we(clr_lo_we),
        .clr_hi_we(clr_hi_we),
        .wdata    (reg_wdata),
        .pend_q   (pend_q)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_EN_SET:  reg_rdata[NUM_CH-1:0] = en_q;
            OFS_MISS:    reg_rdata[NUM_CH-1:0] = miss_q;
            OFS_BUSY:    reg_rdata[NUM_CH-1:0] = busy_q;
            OFS_PEND_LO: reg_rdata = pend_q[31:0];
            OFS_PEND_HI: reg_rdata = pend_q[63:32];
            default: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (reg_addr == OFS_LINK + AW'(4 * c)) begin
                        reg_rdata[SLOT_LSB +: SLOT_W] = link_slot[c];
                        reg_rdata[2 +: WORD_W]        = link_word[c];
                    end
                end
            end
        endcase
    end

    // R7: a busy flag being cleared is gone on the next cycle
    p_busy_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_clr[0] && !fire[0]) |=> !busy_q[0]);

endmodule

// File: tb/test_qtc_ctrl.sv
module test_qtc_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        snp_we = 1'b0;
    logic [15:0] snp_addr = '0;
    logic        cmp_valid = 1'b0;
    logic [5:0]  cmp_code = '0;
    logic        req_valid;
    logic [2:0]  req_ch;
    logic [8:0]  req_slot;

    int total = 0;
    int bad = 0;
    logic [63:0] pend_m = '0;

    always #10 clk = ~clk;

    qtc_ctrl i_qtc_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .snp_we(snp_we),
        .snp_addr(snp_addr), .cmp_valid(cmp_valid), .cmp_code(cmp_code),
        .req_valid(req_valid), .req_ch(req_ch), .req_slot(req_slot)
    );

    function automatic logic [31:0] link_val(input logic [8:0] s, input logic [2:0] w);
        return {18'd0, s, w, 2'b00};
    endfunction

    function automatic logic [15:0] slot_addr(input logic [8:0] s, input logic [2:0] w);
        return 16'h4000 + {2'b00, s, 5'b0} + {11'd0, w, 2'b00};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [15:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic snoop(input logic [15:0] a);
        @(negedge clk);
        snp_we = 1'b1; snp_addr = a;
        @(negedge clk);
        snp_we = 1'b0;
    endtask

    task automatic req_chk(input string tag, input logic v, input logic [2:0] ch, input logic [8:0] s);
        check(tag, {31'd0, req_valid}, {31'd0, v});
        if (v) begin
            check(tag, {29'd0, req_ch}, {29'd0, ch});
            check(tag, {23'd0, req_slot}, {23'd0, s});
        end
    endtask

    task automatic no_req_window(input string tag);
        for (int k = 0; k < 4; k++) begin
            req_chk(tag, 1'b0, 3'd0, 9'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h0005_eed1));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd("R1 enable", 16'h0300, 0);
        rd("R1 missed", 16'h0308, 0);
        rd("R1 busy", 16'h0310, 0);
        rd("R1 pend lo", 16'h0320, 0);
        rd("R1 pend hi", 16'h0324, 0);
        rd("R1 link3", 16'h020C, 0);
        req_chk("R1 req", 1'b0, 3'd0, 9'd0);

        // R2 link registers
        wr(16'h020C, link_val(9'h1A5, 3'd5));
        rd("R2 link3 readback", 16'h020C, link_val(9'h1A5, 3'd5));
        wr(16'h021C, 32'hFFFF_FFFF);
        rd("R2 link7 masked", 16'h021C, 32'h0000_3FFC);

        // R3 enable set and clear
        wr(16'h0300, 32'h0A);
        wr(16'h0300, 32'h01);
        rd("R3 set accumulates", 16'h0300, 32'h0B);
        wr(16'h0304, 32'h02);
        rd("R3 clear one", 16'h0300, 32'h09);
        rd("R3 clear reads zero", 16'h0304, 0);

        // R4 trigger on channel 3
        snoop(slot_addr(9'h1A5, 3'd5));
        req_chk("R4 not yet", 1'b0, 3'd0, 9'd0);
        @(negedge clk);
        req_chk("R4 pulse", 1'b1, 3'd3, 9'h1A5);
        @(negedge clk);
        req_chk("R4 single", 1'b0, 3'd0, 9'd0);
        rd("R4 busy", 16'h0310, 32'h08);

        // R5 trigger while busy
        snoop(slot_addr(9'h1A5, 3'd5));
        no_req_window("R5 no request");
        rd("R5 missed", 16'h0308, 32'h08);

        // R6 disabled channel 7 and unlinked channel 0
        snoop(slot_addr(9'h1FF, 3'd7));
        no_req_window("R6 disabled no request");
        snoop(slot_addr(9'h000, 3'd0));
        no_req_window("R6 unlinked no request");
        rd("R6 busy unchanged", 16'h0310, 32'h08);
        rd("R6 missed unchanged", 16'h0308, 32'h08);

        // R7 clears
        wr(16'h0314, 32'h08);
        rd("R7 busy cleared", 16'h0310, 0);
        wr(16'h030C, 32'h08);
        rd("R7 missed cleared", 16'h0308, 0);
        rd("R7 busy clr reads zero", 16'h0314, 0);
        rd("R7 miss clr reads zero", 16'h030C, 0);

        // R8 two channels on one word, ascending order
        wr(16'h0200, link_val(9'h042, 3'd1));
        wr(16'h0214, link_val(9'h042, 3'd1));
        wr(16'h0300, 32'h21);
        snoop(slot_addr(9'h042, 3'd1));
        req_chk("R8 gap0", 1'b0, 3'd0, 9'd0);
        @(negedge clk);
        req_chk("R8 first ch0", 1'b1, 3'd0, 9'h042);
        @(negedge clk);
        req_chk("R8 gap1", 1'b0, 3'd0, 9'd0);
        @(negedge clk);
        req_chk("R8 second ch5", 1'b1, 3'd5, 9'h042);
        @(negedge clk);
        req_chk("R8 done", 1'b0, 3'd0, 9'd0);
        rd("R8 busy both", 16'h0310, 32'h21);

        // R2 unlink channel 0, only channel 5 fires
        wr(16'h0200, 32'h0);
        wr(16'h0314, 32'hFF);
        snoop(slot_addr(9'h042, 3'd1));
        @(negedge clk);
        req_chk("R2 unlinked skip", 1'b1, 3'd5, 9'h042);
        rd("R2 unlinked busy", 16'h0310, 32'h20);

        // R9 boundary codes
        foreach (pend_m[i]) pend_m[i] = 1'b0;
        for (int k = 0; k < 4; k++) begin
            logic [5:0] c;
            c = (k == 0) ? 6'd0 : (k == 1) ? 6'd31 : (k == 2) ? 6'd32 : 6'd63;
            @(negedge clk);
            cmp_valid = 1'b1; cmp_code = c;
            @(negedge clk);
            cmp_valid = 1'b0;
            pend_m[c] = 1'b1;
        end
        rd("R9 low word", 16'h0320, pend_m[31:0]);
        rd("R9 high word", 16'h0324, pend_m[63:32]);

        // R10 set wins over clear in the same cycle
        @(negedge clk);
        cmp_valid = 1'b1; cmp_code = 6'd40;
        reg_we = 1'b1; reg_addr = 16'h032C; reg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        cmp_valid = 1'b0; reg_we = 1'b0;
        pend_m[63:32] = 32'h0000_0100;
        rd("R10 set wins", 16'h0324, pend_m[63:32]);
        rd("R10 clr reads zero", 16'h0328, 0);

        // R9 R10 random completions and clears
        for (int n = 0; n < 300; n++) begin
            logic [5:0]  c;
            logic        v, cl, ch;
            logic [31:0] m;
            c  = 6'($urandom_range(0, 63));
            v  = 1'($urandom_range(0, 1));
            cl = ($urandom_range(0, 3) == 0);
            ch = 1'($urandom_range(0, 1));
            m  = $urandom;
            @(negedge clk);
            cmp_valid = v; cmp_code = c;
            reg_we = cl; reg_addr = ch ? 16'h032C : 16'h0328; reg_wdata = m;
            @(negedge clk);
            cmp_valid = 1'b0; reg_we = 1'b0;
            if (cl) begin
                if (ch) pend_m[63:32] = pend_m[63:32] & ~m;
                else    pend_m[31:0]  = pend_m[31:0] & ~m;
            end
            if (v) pend_m[c] = 1'b1;
            if (n % 10 == 9) begin
                rd("R9 random low", 16'h0320, pend_m[31:0]);
                rd("R10 random high", 16'h0324, pend_m[63:32]);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule